// File: doc/BRIEF.md
# Console Terminal Receive Controller

This block is the receive half of a console terminal controller sitting on a CPU's programmed I/O bus. Software arms it with a start command, which raises the Busy flag to show the driver is waiting for a character. The controller watches an asynchronous serial line, assembles one 8-bit character, and on a clean frame drops Busy, raises Done and asserts an interrupt request. The driver then reads input register A, which returns the character zero-extended to a 16-bit word. It can clear the flags in the same bus operation.

The serial line passes through a multi-flop synchroniser. A falling edge on the idle line starts a frame. The start bit is confirmed half a bit period later, and each of 8 data bits (least significant first) is then sampled in the middle of its bit period. The frame ends with a stop bit that must read high. A frame with a bad stop bit is discarded. A character that arrives while the controller is not armed is dropped. In both cases the held character is left unchanged.

Top module: `term_rx_ctrl`

## Requirements
- R1: After reset, busy_o, done_o and irq_o are 0 and a read of register A returns 16'h0000.
- R2: A command with control code 2'b01 (start) sets Busy and clears Done on the following cycle.
- R3: While Busy is set, a frame with a start bit, 8 data bits least significant first, each taken at mid-bit, and a high stop bit stores the character, clears Busy and sets Done.
- R4: irq_o is high exactly when Done is set.
- R5: A bus read (cmd_valid_i with cmd_xfer_i high) returns the held character in bits 7:0 and zero in bits 15:8. The data bus reads 0 when no transfer is requested.
- R6: Control code 2'b10 (clear) clears both Busy and Done on the following cycle. When combined with a read, it still returns the held character in that same cycle.
- R7: A frame whose stop bit samples low is discarded: Busy stays set, Done stays clear and the held character does not change.
- R8: A complete valid frame arriving while Busy is clear is dropped: Done stays as it was and the held character does not change.
- R9: A low pulse on the idle line that is shorter than half a bit period does not start a frame and does not disturb reception of the next real frame.
- R10: Control code 2'b11 (pulse) and code 2'b00 (none) leave Busy and Done unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Asynchronous serial receive line, idle high |
| cmd_valid_i | input | 1 | One-cycle strobe for a bus command addressed to this controller |
| cmd_xfer_i | input | 1 | With the strobe: the command reads input register A |
| cmd_ctl_i | input | 2 | Flag control: 00 none, 01 start, 10 clear, 11 pulse |
| rd_data_o | output | 16 | Read data for register A, zero-extended character |
| busy_o | output | 1 | Busy flag, armed and waiting for a character |
| done_o | output | 1 | Done flag, a character is waiting |
| irq_o | output | 1 | Interrupt request |

## Verification
Clean frames carrying directed bytes (0xA5, 0x3C, 0x00, 0xFF) and random bytes check that bit order and mid-bit sampling are right. A byte with mixed bits exposes reversed or shifted assembly. Frames with a low stop bit separate framing rejection from acceptance. The same frames sent while not armed show that capture is gated by Busy. A short glitch followed by a real frame shows that the start bit is qualified rather than taken on the edge alone. Random interleavings of start, clear, pulse and read-with-clear commands are compared against a flag model in the bench, which catches errors in command priority and in zero extension.

// File: rtl/term_rx_pkg.sv
`timescale 1ns/1ps
package term_rx_pkg;

  typedef enum logic [1:0] {
    CTL_NONE  = 2'b00,
    CTL_START = 2'b01,
    CTL_CLEAR = 2'b10,
    CTL_PULSE = 2'b11
  } ctl_e;

  typedef struct packed {
    logic busy;
    logic done;
  } flags_t;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;

  // Flag update: frame completion first, then a command overrides it.
  function automatic flags_t flags_next(flags_t cur, logic cmd_v, ctl_e ctl,
                                        logic byte_ok);
    flags_t nxt;
    nxt = cur;
    if (byte_ok && cur.busy) begin
      nxt.busy = 1'b0;
      nxt.done = 1'b1;
    end
    if (cmd_v) begin
      unique case (ctl)
        CTL_START: begin nxt.busy = 1'b1; nxt.done = 1'b0; end
        CTL_CLEAR: begin nxt.busy = 1'b0; nxt.done = 1'b0; end
        default:   nxt = nxt;
      endcase
    end
    return nxt;
  endfunction

  // Character to bus word: upper bits forced to zero.
  function automatic logic [15:0] zext_byte(logic [7:0] b);
    return {8'h00, b};
  endfunction

  // Insert a sampled bit at the top; after 8 shifts the first bit is bit 0.
  function automatic logic [7:0] shift_lsb_first(logic [7:0] sr, logic bit_in);
    return {bit_in, sr[7:1]};
  endfunction

endpackage

// File: rtl/term_rx_sync.sv
`timescale 1ns/1ps
module term_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b1;
          else        chain_q[0] <= d_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b1;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/term_rx_deser.sv
`timescale 1ns/1ps
module term_rx_deser
  import term_rx_pkg::*;
#(
  parameter int CLKS_PER_BIT = 16,
  parameter int DATA_BITS    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_s_i,
  output logic                 frame_ok_o,
  output logic                 frame_err_o,
  output logic [DATA_BITS-1:0] frame_byte_o
);
  localparam int CW = (CLKS_PER_BIT > 2) ? $clog2(CLKS_PER_BIT) : 1;
  localparam int BW = (DATA_BITS > 2) ? $clog2(DATA_BITS) : 1;
  localparam logic [CW-1:0] FULL_M1 = CW'(CLKS_PER_BIT - 1);
  localparam logic [CW-1:0] HALF_M1 = CW'(CLKS_PER_BIT / 2 - 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(DATA_BITS - 1);

  rx_state_e            state_q;
  logic [CW-1:0]        cnt_q;
  logic [BW-1:0]        bit_q;
  logic [DATA_BITS-1:0] sr_q;
  logic                 prev_q;
  logic                 tick;
  logic                 fall_edge;

  assign tick      = (cnt_q == '0);
  assign fall_edge = prev_q & ~rx_s_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= RX_IDLE;
      cnt_q       <= '0;
      bit_q       <= '0;
      sr_q        <= '0;
      prev_q      <= 1'b1;
      frame_ok_o  <= 1'b0;
      frame_err_o <= 1'b0;
    end else begin
      prev_q      <= rx_s_i;
      frame_ok_o  <= 1'b0;
      frame_err_o <= 1'b0;
      if (!tick) cnt_q <= cnt_q - 1'b1;
      unique case (state_q)
        RX_IDLE: begin
          if (fall_edge) begin
            state_q <= RX_START;
            cnt_q   <= HALF_M1;
          end
        end
        RX_START: begin
          if (tick) begin
            if (!rx_s_i) begin
              state_q <= RX_DATA;
              cnt_q   <= FULL_M1;
              bit_q   <= '0;
            end else begin
              state_q <= RX_IDLE;
            end
          end
        end
        RX_DATA: begin
          if (tick) begin
            sr_q  <= shift_lsb_first(sr_q, rx_s_i);
            cnt_q <= FULL_M1;
            if (bit_q == LAST_BIT) state_q <= RX_STOP;
            else                   bit_q   <= bit_q + 1'b1;
          end
        end
        RX_STOP: begin
          if (tick) begin
            state_q     <= RX_IDLE;
            frame_ok_o  <= rx_s_i;
            frame_err_o <= ~rx_s_i;
          end
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end

  assign frame_byte_o = sr_q;
endmodule

// File: rtl/term_rx_flags.sv
`timescale 1ns/1ps
module term_rx_flags
  import term_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid_i,
  input  logic [1:0] cmd_ctl_i,
  input  logic       frame_ok_i,
  input  logic [7:0] frame_byte_i,
  output logic       busy_o,
  output logic       done_o,
  output logic [7:0] hold_o
);
  flags_t flags_q, flags_d;
  logic   accept;

  assign accept  = frame_ok_i & flags_q.busy;
  assign flags_d = flags_next(flags_q, cmd_valid_i, ctl_e'(cmd_ctl_i), frame_ok_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      hold_o  <= '0;
    end else begin
      flags_q <= flags_d;
      if (accept) hold_o <= frame_byte_i;
    end
  end

  assign busy_o = flags_q.busy;
  assign done_o = flags_q.done;
endmodule

// File: rtl/term_rx_ctrl.sv
`timescale 1ns/1ps
module term_rx_ctrl
  import term_rx_pkg::*;
#(
  parameter int CLKS_PER_BIT = 16,
  parameter int SYNC_STAGES  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_i,
  input  logic        cmd_valid_i,
  input  logic        cmd_xfer_i,
  input  logic [1:0]  cmd_ctl_i,
  output logic [15:0] rd_data_o,
  output logic        busy_o,
  output logic        done_o,
  output logic        irq_o
);
  logic       rx_s;
  logic       frame_ok;
  logic       frame_err;
  logic [7:0] frame_byte;
  logic [7:0] hold_byte;
  logic       rd_strobe;

  term_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(rx_i), .q_o(rx_s)
  );

  term_rx_deser #(.CLKS_PER_BIT(CLKS_PER_BIT), .DATA_BITS(8)) u_deser (
    .clk(clk), .rst_n(rst_n), .rx_s_i(rx_s),
    .frame_ok_o(frame_ok), .frame_err_o(frame_err), .frame_byte_o(frame_byte)
  );

  term_rx_flags u_flags (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid_i(cmd_valid_i), .cmd_ctl_i(cmd_ctl_i),
    .frame_ok_i(frame_ok), .frame_byte_i(frame_byte),
    .busy_o(busy_o), .done_o(done_o), .hold_o(hold_byte)
  );

  assign rd_strobe = cmd_valid_i & cmd_xfer_i;
  assign rd_data_o = rd_strobe ? zext_byte(hold_byte) : 16'h0000;
  assign irq_o     = done_o;
endmodule

// File: rtl/term_rx_ctrl_chk.sv
`timescale 1ns/1ps
module term_rx_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid_i,
  input logic [1:0]  cmd_ctl_i,
  input logic [15:0] rd_data_o,
  input logic        busy_o,
  input logic        done_o,
  input logic        irq_o,
  input logic        frame_ok,
  input logic        frame_err,
  input logic [7:0]  hold_byte
);
  // R2
  start_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && cmd_ctl_i == 2'b01) |=> (busy_o && !done_o));

  // R3
  accept_sets_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ok && busy_o && !cmd_valid_i) |=> (done_o && !busy_o));

  // R4
  irq_follows_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == done_o);

  // R5
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_o[15:8] == 8'h00);

  // R6
  clear_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && cmd_ctl_i == 2'b10) |=> (!busy_o && !done_o));

  // R7
  bad_stop_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_err && !cmd_valid_i) |=> ($stable(busy_o) && $stable(done_o) && $stable(hold_byte)));

  // R8
  unarmed_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ok && !busy_o && !cmd_valid_i) |=> ($stable(done_o) && $stable(hold_byte)));

  // R10
  no_flag_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_ok && (!cmd_valid_i || cmd_ctl_i == 2'b11 || cmd_ctl_i == 2'b00))
      |=> ($stable(busy_o) && $stable(done_o)));

  // R3
  done_only_from_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(frame_ok));
endmodule

bind term_rx_ctrl term_rx_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid_i), .cmd_ctl_i(cmd_ctl_i),
  .rd_data_o(rd_data_o), .busy_o(busy_o), .done_o(done_o), .irq_o(irq_o),
  .frame_ok(frame_ok), .frame_err(frame_err), .hold_byte(hold_byte)
);

// File: tb/tb_term_rx_ctrl.sv
`timescale 1ns/1ps
module tb_term_rx_ctrl;
  localparam int CPB = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_i = 1'b1;
  logic        cmd_valid_i = 1'b0;
  logic        cmd_xfer_i = 1'b0;
  logic [1:0]  cmd_ctl_i = 2'b00;
  logic [15:0] rd_data_o;
  logic        busy_o, done_o, irq_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit exp_busy = 0, exp_done = 0;
  logic [7:0] exp_byte = 8'h00;
  logic [15:0] got;

  always #2.5 clk = ~clk;

  term_rx_ctrl #(.CLKS_PER_BIT(CPB)) dut (
    .clk(clk), .rst_n(rst_n), .rx_i(rx_i), .cmd_valid_i(cmd_valid_i),
    .cmd_xfer_i(cmd_xfer_i), .cmd_ctl_i(cmd_ctl_i), .rd_data_o(rd_data_o),
    .busy_o(busy_o), .done_o(done_o), .irq_o(irq_o)
  );

  function automatic logic [15:0] exp_word(logic [7:0] b);
    logic [15:0] w;
    w = '0;
    for (int i = 0; i < 8; i++) w[i] = b[i];
    return w;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic check_flags(string req);
    check(busy_o == exp_busy, {req, " busy"}, busy_o, exp_busy);
    check(done_o == exp_done, {req, " done"}, done_o, exp_done);
    check(irq_o == exp_done, "R4 irq", irq_o, exp_done);
  endtask

  task automatic cmd(logic [1:0] ctl, logic xfer);
    @(negedge clk);
    cmd_valid_i = 1'b1; cmd_xfer_i = xfer; cmd_ctl_i = ctl;
    #1 got = rd_data_o;
    @(negedge clk);
    cmd_valid_i = 1'b0; cmd_xfer_i = 1'b0; cmd_ctl_i = 2'b00;
    if (ctl == 2'b01) begin exp_busy = 1; exp_done = 0; end
    if (ctl == 2'b10) begin exp_busy = 0; exp_done = 0; end
  endtask

  task automatic read_a(string req);
    cmd(2'b00, 1'b1);
    check(got == exp_word(exp_byte), req, got, exp_word(exp_byte));
  endtask

  task automatic send_frame(logic [7:0] b, logic stop_bit);
    @(negedge clk);
    rx_i = 1'b0; repeat (CPB) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx_i = b[i]; repeat (CPB) @(negedge clk);
    end
    rx_i = stop_bit; repeat (CPB) @(negedge clk);
    rx_i = 1'b1; repeat (CPB) @(negedge clk);
    if (stop_bit && exp_busy) begin
      exp_busy = 0; exp_done = 1; exp_byte = b;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    check_flags("R1");
    check(rd_data_o == 16'h0, "R1 data idle", rd_data_o, 0);
    read_a("R1 read");

    // R8 frame while not armed is dropped
    send_frame(8'h5A, 1'b1);
    check_flags("R8");
    read_a("R8 hold unchanged");

    // R2 start
    cmd(2'b01, 1'b0);
    check_flags("R2");

    // R3 good frame, R5 read format
    send_frame(8'hA5, 1'b1);
    check_flags("R3");
    read_a("R5 zero-extended");
    check_flags("R5 plain read keeps flags");

    // R10 pulse leaves flags
    cmd(2'b11, 1'b0);
    check_flags("R10 pulse");
    cmd(2'b00, 1'b0);
    check_flags("R10 none");

    // R6 read with clear
    cmd(2'b10, 1'b1);
    check(got == exp_word(8'hA5), "R6 data", got, exp_word(8'hA5));
    check_flags("R6");

    // R7 bad stop bit
    cmd(2'b01, 1'b0);
    send_frame(8'hC3, 1'b0);
    check_flags("R7");
    read_a("R7 hold unchanged");

    // R9 short glitch then real frame
    rx_i = 1'b0; repeat (CPB/4) @(negedge clk);
    rx_i = 1'b1; repeat (2*CPB) @(negedge clk);
    check_flags("R9 glitch ignored");
    send_frame(8'h3C, 1'b1);
    check_flags("R9 frame after glitch");
    read_a("R9 byte");

    // R8 after done: unarmed frame leaves byte and done
    send_frame(8'hFF, 1'b1);
    check_flags("R8 done kept");
    read_a("R8 byte kept");

    // R3 corner bytes
    cmd(2'b01, 1'b0);
    send_frame(8'h00, 1'b1);
    read_a("R3 byte 00");
    cmd(2'b01, 1'b0);
    send_frame(8'hFF, 1'b1);
    read_a("R3 byte FF");
    check_flags("R3 FF flags");

    // Random mix of R3 R6 R7 R8
    for (int k = 0; k < 24; k++) begin
      logic [7:0] b;
      logic       stop;
      b = 8'($urandom);
      stop = ($urandom % 8) != 0;
      case ($urandom % 3)
        0: cmd(2'b01, 1'b0);
        1: cmd(2'b10, 1'b0);
        default: ;
      endcase
      send_frame(b, stop);
      check_flags("R3/R7/R8 random");
      if ($urandom % 2) begin
        cmd(2'b10, 1'b1);
        check(got == exp_word(exp_byte), "R6 random read-clear", got, exp_word(exp_byte));
        check_flags("R6 random");
      end else begin
        read_a("R5 random read");
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule